// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps speculative instructions of a dual-issue out-of-order core in program order until they can safely update architectural state. It is a ring of entries with a head and a tail pointer. Each cycle up to two instructions are placed at the tail and each receives an entry number, which is used as its rename tag. Execution results come back on a single result bus that carries the entry number. The buffer commits finished entries from the head, at most two per cycle and always in order, to the write ports of the architectural register file.

The buffer is also a renaming store. The two instructions issued together have two source operands each, so four register-name lookups search every live entry's destination. Each lookup returns the youngest matching entry. Age is measured from the head and wraps around the ring. The lookup gives the entry's value when the result has arrived, or only its tag when the result is still pending. When nothing matches, the caller reads the register file.

An entry at the head that finished with an exception, or that is a branch reported as mispredicted, is never committed. It raises a flush that reports its PC, empties the buffer and moves the tail back to the head.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. There is no stall, no commit and no flush, every lookup misses, and the first allocation tag is 0.
- R2: Slot 0 takes the tail entry. Slot 1 takes the tail plus one when slot 0 also requests, and the tail itself when slot 0 does not. Tags wrap modulo 16.
- R3: `alloc_stall` is 1 when the number of requested slots is more than the number of free entries, or when a flush is active. A stalled request allocates nothing, and occupancy never exceeds 16.
- R4: A result with a tag that names a live entry marks that entry complete and stores its value, its exception flag and its mispredict flag.
- R5: A lookup hits when a live entry's 6-bit destination equals the queried register. It returns the youngest such entry, with age counted from the head and wrapping around the ring. Lookups see the buffer as it stands before the coming clock edge.
- R6: A lookup that hits a pending entry returns `lk_ready`=0. A lookup that hits a complete entry returns `lk_ready`=1 and the entry's value. A lookup that misses returns `lk_hit`=0.
- R7: Lookup ports 2 and 3 serve the second instruction of the pair. When slot 0 requests allocation and its destination equals the queried register, the port returns a hit with `alloc_tag0` and `lk_ready`=0.
- R8: The head entry commits when it is complete and has neither an exception nor a mispredict. The outputs carry its destination and value on lane 0. The next entry commits on lane 1 in the same cycle only if lane 0 commits and that entry is also complete and clean.
- R9: When the head entry is complete and flagged (exception or mispredict), `flush` is 1, `flush_pc` carries that entry's PC and nothing commits. From the next cycle the buffer is empty, and the next allocation gets the old head as its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 2 | Allocation request per issue slot |
| alloc_dst0 | input | 6 | Destination register of slot 0 |
| alloc_dst1 | input | 6 | Destination register of slot 1 |
| alloc_pc0 | input | 32 | PC of slot 0 |
| alloc_pc1 | input | 32 | PC of slot 1 |
| alloc_stall | output | 1 | Request cannot be accepted this cycle |
| alloc_tag0 | output | 4 | Entry given to slot 0 |
| alloc_tag1 | output | 4 | Entry given to slot 1 |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | 4 | Entry the result belongs to |
| res_value | input | 32 | Result value |
| res_exc | input | 1 | Instruction raised an exception |
| res_misp | input | 1 | Branch was mispredicted |
| lk_reg | input | 4x6 | Source register queried per lookup port |
| lk_hit | output | 4 | A live entry targets the register |
| lk_ready | output | 4 | The hit entry holds its value |
| lk_tag | output | 4x4 | Entry number of the hit |
| lk_value | output | 4x32 | Value of the hit entry |
| cm_valid | output | 2 | Commit lane active |
| cm_reg | output | 2x6 | Register written by each commit lane |
| cm_value | output | 2x32 | Value written by each commit lane |
| flush | output | 1 | Head entry forces a squash |
| flush_pc | output | 32 | PC of the squashing entry |

## Verification
Allocation and retirement fall in the same cycle most often. The free count that decides the stall is then computed before that cycle's commits, and the new tags must land on entries that are still being freed or filled. A long stimulus sweep keeps the ring near full while results arrive in scrambled order, so pairs are allocated in the same cycles that entries commit or flush. The bench keeps its own queue model of the ring and predicts every stall, tag, commit lane and lookup from that model. A flagged head that meets an allocation request is judged on the stall it raises, on the empty ring it leaves and on the tag the following allocation receives.

// File: rtl/rob_pkg.sv
// Shared definitions for the reorder buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package rob_pkg;

    // Condition of the oldest entry, decided each cycle by the retire logic.
    typedef enum logic [1:0] {
        HS_EMPTY  = 2'd0,
        HS_WAIT   = 2'd1,
        HS_RETIRE = 2'd2,
        HS_SQUASH = 2'd3
    } head_state_e;

endpackage

// File: rtl/rob_lookup.sv
// One associative source-operand port. It returns the youngest live entry
// whose destination equals the queried register. Age is counted from the head.
// Assumes DEPTH is a power of two, so ring indices wrap in IDXW bits.
module rob_lookup #(
    parameter int DEPTH = 16,
    parameter int RW    = 6,
    parameter int DW    = 32,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic [IDXW-1:0]           head,
    input  logic [IDXW:0]             count,
    input  logic [DEPTH-1:0][RW-1:0]  e_dst,
    input  logic [DEPTH-1:0]          e_done,
    input  logic [DEPTH-1:0][DW-1:0]  e_val,
    input  logic [RW-1:0]             query,
    output logic                      hit,
    output logic                      ready,
    output logic [IDXW-1:0]           tag,
    output logic [DW-1:0]             value
);

    // Scan from oldest to youngest so that the last match wins.
    always_comb begin
        hit = 1'b0;
        tag = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDXW-1:0] idx;
            idx = head + IDXW'(k);
            if ((IDXW+1)'(k) < count && e_dst[idx] == query) begin
                hit = 1'b1;
                tag = idx;
            end
        end
    end

    // Present the readiness and the value of the chosen entry.
    always_comb begin
        ready = hit & e_done[tag];
        value = e_val[tag];
    end

endmodule

// File: rtl/rob_retire.sv
// Head-side decision logic: in-order commit over two lanes, and squash
// detection. Lane 1 commits only if lane 0 commits.
// Assumes DEPTH is a power of two.
module rob_retire
    import rob_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int RW    = 6,
    parameter int DW    = 32,
    parameter int PCW   = 32,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input  logic [IDXW-1:0]           head,
    input  logic [IDXW:0]             count,
    input  logic [DEPTH-1:0]          e_done,
    input  logic [DEPTH-1:0]          e_exc,
    input  logic [DEPTH-1:0]          e_misp,
    input  logic [DEPTH-1:0][RW-1:0]  e_dst,
    input  logic [DEPTH-1:0][DW-1:0]  e_val,
    input  logic [DEPTH-1:0][PCW-1:0] e_pc,
    output logic [1:0]                cm_valid,
    output logic [1:0][RW-1:0]        cm_reg,
    output logic [1:0][DW-1:0]        cm_value,
    output logic [1:0]                n_commit,
    output logic                      squash,
    output logic [PCW-1:0]            squash_pc
);

    logic [IDXW-1:0] h1;
    head_state_e     hstate;
    logic            second_ok;

    // Classify the oldest entry.
    always_comb begin
        h1 = head + 1'b1;
        if (count == '0)
            hstate = HS_EMPTY;
        else if (!e_done[head])
            hstate = HS_WAIT;
        else if (e_exc[head] || e_misp[head])
            hstate = HS_SQUASH;
        else
            hstate = HS_RETIRE;
    end

    // Decide both lanes; the second depends on the first.
    always_comb begin
        second_ok   = (count >= (IDXW+1)'(2)) && e_done[h1] && !e_exc[h1] && !e_misp[h1];
        cm_valid[0] = (hstate == HS_RETIRE);
        cm_valid[1] = cm_valid[0] && second_ok;
        cm_reg[0]   = e_dst[head];
        cm_reg[1]   = e_dst[h1];
        cm_value[0] = e_val[head];
        cm_value[1] = e_val[h1];
        n_commit    = {1'b0, cm_valid[0]} + {1'b0, cm_valid[1]};
        squash      = (hstate == HS_SQUASH);
        squash_pc   = e_pc[head];
    end

endmodule

// File: rtl/rob_core.sv
// Reorder buffer top. Holds the entry storage, the ring pointers and the
// two-slot allocation, and places the retire logic and four lookup ports.
// Assumes DEPTH is a power of two and that at most one result arrives per cycle.
module rob_core #(
    parameter int DEPTH  = 16,
    parameter int NREGS  = 64,
    parameter int DW     = 32,
    parameter int PCW    = 32,
    parameter int NPORTS = 4,
    localparam int RW    = $clog2(NREGS),
    localparam int IDXW  = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    alloc_req,
    input  logic [RW-1:0]                 alloc_dst0,
    input  logic [RW-1:0]                 alloc_dst1,
    input  logic [PCW-1:0]                alloc_pc0,
    input  logic [PCW-1:0]                alloc_pc1,
    output logic                          alloc_stall,
    output logic [IDXW-1:0]               alloc_tag0,
    output logic [IDXW-1:0]               alloc_tag1,
    input  logic                          res_valid,
    input  logic [IDXW-1:0]               res_tag,
    input  logic [DW-1:0]                 res_value,
    input  logic                          res_exc,
    input  logic                          res_misp,
    input  logic [NPORTS-1:0][RW-1:0]     lk_reg,
    output logic [NPORTS-1:0]             lk_hit,
    output logic [NPORTS-1:0]             lk_ready,
    output logic [NPORTS-1:0][IDXW-1:0]   lk_tag,
    output logic [NPORTS-1:0][DW-1:0]     lk_value,
    output logic [1:0]                    cm_valid,
    output logic [1:0][RW-1:0]            cm_reg,
    output logic [1:0][DW-1:0]            cm_value,
    output logic                          flush,
    output logic [PCW-1:0]                flush_pc
);

    localparam int HALF = NPORTS / 2;

    logic [IDXW-1:0]           head, tail;
    logic [IDXW:0]             count;
    logic [DEPTH-1:0][RW-1:0]  e_dst;
    logic [DEPTH-1:0][DW-1:0]  e_val;
    logic [DEPTH-1:0][PCW-1:0] e_pc;
    logic [DEPTH-1:0]          e_done, e_exc, e_misp, e_live;
    logic [1:0]                n_commit, n_req, n_alloc;
    logic [IDXW:0]             free_cnt;
    logic                      acc0, acc1;

    // Mark which ring positions currently hold a live entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [IDXW-1:0] age;
            age       = IDXW'(i) - head;
            e_live[i] = {1'b0, age} < count;
        end
    end

    // Head-side commit and squash decisions.
    rob_retire #(.DEPTH(DEPTH), .RW(RW), .DW(DW), .PCW(PCW)) u_retire (
        .head      (head),
        .count     (count),
        .e_done    (e_done),
        .e_exc     (e_exc),
        .e_misp    (e_misp),
        .e_dst     (e_dst),
        .e_val     (e_val),
        .e_pc      (e_pc),
        .cm_valid  (cm_valid),
        .cm_reg    (cm_reg),
        .cm_value  (cm_value),
        .n_commit  (n_commit),
        .squash    (flush),
        .squash_pc (flush_pc)
    );

    // Decide whether the requested slots fit and which tags they get.
    always_comb begin
        n_req       = {1'b0, alloc_req[0]} + {1'b0, alloc_req[1]};
        free_cnt    = (IDXW+1)'(DEPTH) - count;
        alloc_stall = flush || ({{(IDXW-1){1'b0}}, n_req} > free_cnt);
        acc0        = alloc_req[0] && !alloc_stall;
        acc1        = alloc_req[1] && !alloc_stall;
        n_alloc     = alloc_stall ? 2'd0 : n_req;
        alloc_tag0  = tail;
        alloc_tag1  = tail + IDXW'(alloc_req[0]);
    end

    // Lookup ports; the second instruction's ports also see slot 0's write.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic            b_hit, b_ready;
        logic [IDXW-1:0] b_tag;
        logic [DW-1:0]   b_value;

        rob_lookup #(.DEPTH(DEPTH), .RW(RW), .DW(DW)) u_lookup (
            .head   (head),
            .count  (count),
            .e_dst  (e_dst),
            .e_done (e_done),
            .e_val  (e_val),
            .query  (lk_reg[p]),
            .hit    (b_hit),
            .ready  (b_ready),
            .tag    (b_tag),
            .value  (b_value)
        );

        if (p >= HALF) begin : g_pair
            // Override with the partner instruction's new tag on a name match.
            always_comb begin
                if (alloc_req[0] && alloc_dst0 == lk_reg[p]) begin
                    lk_hit[p]   = 1'b1;
                    lk_ready[p] = 1'b0;
                    lk_tag[p]   = alloc_tag0;
                    lk_value[p] = '0;
                end else begin
                    lk_hit[p]   = b_hit;
                    lk_ready[p] = b_ready;
                    lk_tag[p]   = b_tag;
                    lk_value[p] = b_value;
                end
            end
        end else begin : g_plain
            // Pass the buffer search straight out.
            always_comb begin
                lk_hit[p]   = b_hit;
                lk_ready[p] = b_ready;
                lk_tag[p]   = b_tag;
                lk_value[p] = b_value;
            end
        end
    end

    // Advance pointers and occupancy; a squash empties the ring at the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else if (flush) begin
            tail  <= head;
            count <= '0;
        end else begin
            head  <= head + IDXW'(n_commit);
            tail  <= tail + IDXW'(n_alloc);
            count <= count + (IDXW+1)'(n_alloc) - (IDXW+1)'(n_commit);
        end
    end

    // Write entry fields from the result bus and from the two issue slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_done <= '0;
            e_exc  <= '0;
            e_misp <= '0;
            e_dst  <= '0;
            e_val  <= '0;
            e_pc   <= '0;
        end else if (flush) begin
            e_done <= '0;
            e_exc  <= '0;
            e_misp <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (res_valid && res_tag == IDXW'(i) && e_live[i]) begin
                    e_done[i] <= 1'b1;
                    e_val[i]  <= res_value;
                    e_exc[i]  <= res_exc;
                    e_misp[i] <= res_misp;
                end
            end
            if (acc0) begin
                e_dst[alloc_tag0]  <= alloc_dst0;
                e_pc[alloc_tag0]   <= alloc_pc0;
                e_done[alloc_tag0] <= 1'b0;
                e_exc[alloc_tag0]  <= 1'b0;
                e_misp[alloc_tag0] <= 1'b0;
            end
            if (acc1) begin
                e_dst[alloc_tag1]  <= alloc_dst1;
                e_pc[alloc_tag1]   <= alloc_pc1;
                e_done[alloc_tag1] <= 1'b0;
                e_exc[alloc_tag1]  <= 1'b0;
                e_misp[alloc_tag1] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rob_chk.sv
// Checker for rob_core: occupancy bound, stall effect, lane order and
// squash behaviour. Attached to every rob_core instance through bind.
module rob_chk #(
    parameter int DEPTH = 16,
    parameter int IDXW  = $clog2(DEPTH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      alloc_req,
    input logic            alloc_stall,
    input logic [IDXW-1:0] alloc_tag0,
    input logic [IDXW-1:0] alloc_tag1,
    input logic [1:0]      cm_valid,
    input logic            flush,
    input logic [IDXW:0]   occ
);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (IDXW+1)'(DEPTH));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_stall && cm_valid == 2'b00 && !flush) |=> (occ == $past(occ)));

    // R2
    pair_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req == 2'b11) |-> (alloc_tag1 == IDXW'(alloc_tag0 + 1'b1)));

    // R8
    lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid[1] |-> cm_valid[0]);

    // R9
    squash_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (cm_valid == 2'b00));

    // R9
    squash_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0 && cm_valid == 2'b00));

endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH)) u_rob_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .alloc_stall (alloc_stall),
    .alloc_tag0  (alloc_tag0),
    .alloc_tag1  (alloc_tag1),
    .cm_valid    (cm_valid),
    .flush       (flush),
    .occ         (count)
);

// File: tb/test_rob_core.sv
`timescale 1ns/1ps
// Bench for rob_core: directed corners followed by a long pseudo-random
// sweep, with every output predicted by a queue model kept in the bench.
module test_rob_core;

    localparam int D = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      alloc_req = '0;
    logic [5:0]      alloc_dst0 = '0, alloc_dst1 = '0;
    logic [31:0]     alloc_pc0 = '0, alloc_pc1 = '0;
    logic            alloc_stall;
    logic [3:0]      alloc_tag0, alloc_tag1;
    logic            res_valid = 1'b0;
    logic [3:0]      res_tag = '0;
    logic [31:0]     res_value = '0;
    logic            res_exc = 1'b0, res_misp = 1'b0;
    logic [3:0][5:0] lk_reg = '0;
    logic [3:0]      lk_hit, lk_ready;
    logic [3:0][3:0] lk_tag;
    logic [3:0][31:0] lk_value;
    logic [1:0]      cm_valid;
    logic [1:0][5:0] cm_reg;
    logic [1:0][31:0] cm_value;
    logic            flush;
    logic [31:0]     flush_pc;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Bench model of the ring.
    int m_dst[D], m_val[D], m_pc[D];
    bit m_done[D], m_exc[D], m_mis[D];
    int m_head = 0, m_cnt = 0, pc_seq = 100;
    int lk_q[4];
    logic [31:0] lfsr = 32'hACE1_2461;

    rob_core i_rob_core (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
        .alloc_dst0(alloc_dst0), .alloc_dst1(alloc_dst1),
        .alloc_pc0(alloc_pc0), .alloc_pc1(alloc_pc1),
        .alloc_stall(alloc_stall), .alloc_tag0(alloc_tag0), .alloc_tag1(alloc_tag1),
        .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
        .res_exc(res_exc), .res_misp(res_misp),
        .lk_reg(lk_reg), .lk_hit(lk_hit), .lk_ready(lk_ready),
        .lk_tag(lk_tag), .lk_value(lk_value),
        .cm_valid(cm_valid), .cm_reg(cm_reg), .cm_value(cm_value),
        .flush(flush), .flush_pc(flush_pc)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rnd(input int m);
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return int'(lfsr[15:0]) % m;
    endfunction

    // One cycle: drive at the falling edge, check, then advance the model.
    task automatic step(input logic [1:0] req, input int d0, input int d1,
                        input bit rv, input int rtag, input int rval,
                        input bit rexc, input bit rmis);
        int h, h1, tl, nreq, ncom;
        bit fl, st, c0, c1;
        @(negedge clk);
        alloc_req = req; alloc_dst0 = 6'(d0); alloc_dst1 = 6'(d1);
        alloc_pc0 = 32'(pc_seq); alloc_pc1 = 32'(pc_seq + 1);
        res_valid = rv; res_tag = 4'(rtag); res_value = 32'(rval);
        res_exc = rexc; res_misp = rmis;
        for (int p = 0; p < 4; p++) lk_reg[p] = 6'(lk_q[p]);
        #1;
        h = m_head; h1 = (h + 1) % D; tl = (h + m_cnt) % D;
        nreq = int'(req[0]) + int'(req[1]);
        fl = m_cnt > 0 && m_done[h] && (m_exc[h] || m_mis[h]);
        st = fl || nreq > D - m_cnt;
        c0 = !fl && m_cnt > 0 && m_done[h];
        c1 = c0 && m_cnt > 1 && m_done[h1] && !m_exc[h1] && !m_mis[h1];
        chk("R3 stall", alloc_stall, st);
        if (req != 2'b00) begin
            chk("R2 tag0", alloc_tag0, tl);
            chk("R2 tag1", alloc_tag1, (tl + int'(req[0])) % D);
        end
        chk("R8 lane0", cm_valid[0], c0);
        chk("R8 lane1", cm_valid[1], c1);
        if (c0) begin
            chk("R8 reg0", cm_reg[0], m_dst[h]);
            chk("R8 val0", cm_value[0], m_val[h]);
        end
        if (c1) begin
            chk("R8 reg1", cm_reg[1], m_dst[h1]);
            chk("R8 val1", cm_value[1], m_val[h1]);
        end
        chk("R9 flush", flush, fl);
        if (fl) chk("R9 flush_pc", flush_pc, m_pc[h]);
        for (int p = 0; p < 4; p++) begin
            bit eh = 0, er = 0, byp = 0;
            int et = 0, ev = 0;
            for (int k = 0; k < m_cnt; k++) begin
                int idx = (h + k) % D;
                if (m_dst[idx] == lk_q[p]) begin
                    eh = 1; et = idx; er = m_done[idx]; ev = m_val[idx];
                end
            end
            if (p >= 2 && req[0] && d0 == lk_q[p]) begin
                byp = 1; eh = 1; et = tl; er = 0;
            end
            chk(byp ? "R7 hit" : "R5 hit", lk_hit[p], eh);
            if (eh) begin
                chk(byp ? "R7 tag" : "R5 tag", lk_tag[p], et);
                chk(byp ? "R7 ready" : "R6 ready", lk_ready[p], er);
            end
            if (er) chk("R6 value", lk_value[p], ev);
        end
        // Model update for the coming edge.
        if (fl) begin
            m_cnt = 0;
            for (int i = 0; i < D; i++) m_done[i] = 0;
        end else begin
            if (rv && ((rtag - h + D) % D) < m_cnt) begin   // R4
                m_done[rtag] = 1; m_val[rtag] = rval;
                m_exc[rtag] = rexc; m_mis[rtag] = rmis;
            end
            if (!st) begin
                int pos = tl;
                if (req[0]) begin
                    m_dst[pos] = d0; m_pc[pos] = pc_seq; m_done[pos] = 0;
                    m_exc[pos] = 0; m_mis[pos] = 0; pos = (pos + 1) % D;
                end
                if (req[1]) begin
                    m_dst[pos] = d1; m_pc[pos] = pc_seq + 1; m_done[pos] = 0;
                    m_exc[pos] = 0; m_mis[pos] = 0;
                end
            end
            ncom = int'(c0) + int'(c1);
            m_head = (h + ncom) % D;
            m_cnt = m_cnt - ncom + (st ? 0 : nreq);
        end
        pc_seq += 2;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        lk_q = '{1, 2, 3, 4};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        alloc_req = 2'b01;
        for (int p = 0; p < 4; p++) lk_reg[p] = 6'(p + 1);
        #1;
        // R1 reset state
        chk("R1 stall", alloc_stall, 0);
        chk("R1 tag0", alloc_tag0, 0);
        chk("R1 commit", cm_valid, 0);
        chk("R1 flush", flush, 0);
        chk("R1 lookups", lk_hit & 4'b0011, 0);
        alloc_req = 2'b00;

        // Fill the ring with pairs; odd tags complete as the fill proceeds.
        for (int i = 0; i < 8; i++)
            step(2'b11, i % 5, (i + 2) % 5, i > 0, 2 * i - 1, 1000 + 2 * i - 1, 0, 0);
        // R3 a full ring refuses any request.
        step(2'b01, 7, 0, 1, 15, 1015, 0, 0);
        step(2'b11, 7, 8, 0, 0, 0, 0, 0);
        // R4 even tags complete youngest first; the head is the last.
        for (int t = 14; t >= 0; t -= 2) step(2'b00, 0, 0, 1, t, 2000 + t, 0, 0);
        // R8 two commits per cycle while new pairs wrap past the end.
        lk_q = '{0, 2, 4, 1};
        for (int i = 0; i < 10; i++)
            step(2'b11, (i % 3) + 1, 4, 1, (m_head + m_cnt - 1) % D, 3000 + i, 0, 0);
        // R9 exception at the head.
        step(2'b00, 0, 0, 1, m_head, 4000, 1, 0);
        step(2'b11, 1, 2, 0, 0, 0, 0, 0);
        step(2'b11, 3, 4, 0, 0, 0, 0, 0);
        // R9 mispredicted branch at the head.
        step(2'b00, 0, 0, 1, m_head, 4100, 0, 1);
        step(2'b01, 5, 0, 0, 0, 0, 0, 0);
        step(2'b10, 0, 5, 0, 0, 0, 0, 0);

        // Pseudo-random sweep over a small register set.
        for (int i = 0; i < 3000; i++) begin
            int rt = 0;
            bit rv = 0;
            for (int p = 0; p < 4; p++) lk_q[p] = rnd(6);
            if (m_cnt > 0 && rnd(4) != 0) begin
                rv = 1;
                rt = (m_head + rnd(m_cnt)) % D;
            end
            step(2'(rnd(4)), rnd(6), rnd(6), rv, rt, rnd(60000),
                 rnd(29) == 0, rnd(31) == 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule